// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller turns single-beat requests from a clocked internal port into properly timed strobe sequences for an external asynchronous static RAM of 512K bytes. A requester presents a command with a valid/ready handshake: a write flag, a 19-bit word address and a byte of write data. Read results come back as a byte with a single-cycle valid strobe.

On the memory side the block drives three active-low strobes: chip select, write enable and output enable. It also drives the address bus and an 8-bit data path. The data path is split into an output byte, an input byte and a drive enable, which the pad ring joins into one bidirectional bus.

Every phase length is a whole number of clocks. Each is computed at elaboration by rounding a nanosecond limit up to the clock period, so the same source fits any clock rate or speed grade. The bus is handed over so that the controller and the memory never drive it together.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are all high. The data drive enable is low, ready is high and read-valid is low.
- R2: While the controller is idle (ready high), chip select is high.
- R3: A read returns, on rd_data with a one-cycle rd_valid pulse, the byte most recently written to that address. Any address may be used, from 0 to 0x7FFFF.
- R4: Read data is captured on the clock edge that ends the read phase. The read phase lasts max(ceil(T_AA/CLK), ceil(T_OE/CLK)) cycles with chip select and output enable low. Nothing is sampled earlier.
- R5: Write enable stays low for max(ceil(T_WP/CLK), ceil(T_AW/CLK), ceil(T_DW/CLK), ceil(T_WC/CLK)-1) cycles. The address stays stable for as long as chip select is low.
- R6: Output enable stays high throughout every write.
- R7: In a write, write enable falls in the same cycle as chip select, never after it. Write enable is never low while chip select is high.
- R8: The data drive enable rises only when output enable has been high for at least ceil(T_HZ/CLK) cycles. It is never high while output enable is low.
- R9: Ready drops at acceptance and stays low for exactly read-phase + ceil(T_HZ/CLK) cycles for a read. For a write it stays low for the write-enable-low length + 1 cycles.
- R10: rd_valid is never high in two consecutive cycles.
- R11: While the data drive enable is high, mem_dq_o holds the accepted write byte unchanged, including the cycle after write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle, command taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle read result strobe |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_i | input | 8 | Byte received from the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The hardest situation to bring about is a write that directly follows a read, because only then does the bus turnaround gap matter. Back-to-back requests force it: the driver issues the next command on the first cycle that ready returns. A counter in the bench measures how long output enable has been high when the drive enable rises. The memory model returns a junk byte until the access time has fully elapsed, so a capture even one cycle early shows up as a read mismatch.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int T_AA   = 70,
  parameter int T_OE   = 35,
  parameter int T_WC   = 70,
  parameter int T_WP   = 50,
  parameter int T_AW   = 60,
  parameter int T_DW   = 30,
  parameter int T_HZ   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_C  = imax(cyc(T_AA), cyc(T_OE));
  localparam int WL_C  = imax(imax(cyc(T_WP), cyc(T_AW)), imax(cyc(T_DW), cyc(T_WC) - 1));
  localparam int HZ_C  = cyc(T_HZ);
  localparam int MAX_C = imax(imax(RD_C, WL_C), HZ_C);
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WLOW, S_WREL} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign req_ready = (state == S_IDLE);
  assign last      = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_cs_n <= 1'b0;
          if (req_write) begin
            mem_we_n  <= 1'b0;
            mem_dq_o  <= req_wdata;
            mem_dq_oe <= 1'b1;
            cnt       <= CNT_W'(WL_C - 1);
            state     <= S_WLOW;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_C - 1);
            state    <= S_READ;
          end
        end
        S_READ: if (last) begin
          rd_data  <= mem_dq_i;
          rd_valid <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          cnt      <= CNT_W'(HZ_C - 1);
          state    <= S_TURN;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_TURN: if (last) state <= S_IDLE;
                else      cnt   <= cnt - 1'b1;
        S_WLOW: if (last) begin
          mem_we_n <= 1'b1;
          mem_cs_n <= 1'b1;
          state    <= S_WREL;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WREL: begin
          mem_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_oe_off_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_we_inside_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_we_with_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_n) && mem_oe_n) |-> !mem_we_n);

  p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_wdata_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int CLK_NS = 5;
  localparam int RD_EXP = 14;
  localparam int WL_EXP = 13;
  localparam int HZ_EXP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]};
  endfunction

  // memory model and timing monitors
  logic [7:0]  mem [int];
  int          acc_cnt = 0, oe_hi = 100, we_lo = 0;
  logic        prev_oe = 1'b0, prev_we = 1'b1, prev_rv = 1'b0;
  logic [18:0] cs_addr;

  always @(negedge clk) if (rst_n) begin
    if (!mem_cs_n && !mem_we_n) mem[int'(mem_addr)] = mem_dq_o;
    if (mem_cs_n || mem_oe_n) acc_cnt = 0; else acc_cnt++;
    if (acc_cnt >= RD_EXP)
      mem_dq_i = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : dflt(mem_addr);
    else
      mem_dq_i = 8'hEE;
    if (mem_dq_oe && !prev_oe) check(oe_hi >= HZ_EXP, "R8 bus idle before drive", oe_hi, HZ_EXP);
    if (mem_dq_oe && !mem_oe_n) check(1'b0, "R8 drive while output enabled", 1, 0);
    if (mem_oe_n) oe_hi++; else oe_hi = 0;
    if (!mem_we_n) begin
      if (!mem_oe_n) check(1'b0, "R6 output enable low in write", 0, 1);
      if (mem_cs_n) check(1'b0, "R7 write enable outside select", 1, 0);
      we_lo++;
    end
    if (mem_we_n && !prev_we) begin
      check(we_lo == WL_EXP, "R5 write enable low length", we_lo, WL_EXP);
      we_lo = 0;
    end
    if (req_ready && !mem_cs_n) check(1'b0, "R2 select while idle", 0, 1);
    prev_oe = mem_dq_oe;
    prev_we = mem_we_n;
  end

  // scoreboard
  logic [7:0] expq [$];
  logic [7:0] shadow [int];

  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      check(!prev_rv, "R10 valid pulse width", 2, 1);
      if (expq.size() == 0) check(1'b0, "R3 unexpected read data", rd_data, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(rd_data == e, "R3/R4 read data", rd_data, e);
      end
    end
    prev_rv = rd_valid;
  end

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int busy;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      shadow[int'(a)] = d;
      check(!mem_we_n && !mem_cs_n && mem_oe_n, "R7 write strobes together", {mem_cs_n, mem_we_n}, 0);
      check(mem_dq_oe && mem_dq_o == d, "R11 write byte driven", mem_dq_o, d);
      cs_addr = mem_addr;
    end else begin
      expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a));
    end
    busy = 0;
    while (!req_ready) begin
      if (!mem_cs_n && mem_addr != a) check(1'b0, "R5 address moved", mem_addr, a);
      if (mem_dq_oe && mem_dq_o != d) check(1'b0, "R11 write byte moved", mem_dq_o, d);
      busy++;
      @(negedge clk);
    end
    check(busy == (wr ? WL_EXP + 1 : RD_EXP + HZ_EXP), "R9 busy length", busy,
          wr ? WL_EXP + 1 : RD_EXP + HZ_EXP);
  endtask

  initial begin
    #(CLK_NS * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    check(!mem_dq_oe, "R1 bus released in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rd_valid, "R1 ready after reset", {req_ready, rd_valid}, 2);
    check(mem_cs_n, "R2 idle deselect", mem_cs_n, 1);
    do_req(1'b1, 19'h00000, 8'h00);
    do_req(1'b1, 19'h7FFFF, 8'hFF);
    do_req(1'b1, 19'h12345, 8'hA5);
    do_req(1'b0, 19'h12345, 8'h00);
    do_req(1'b1, 19'h00001, 8'h5A);
    do_req(1'b0, 19'h7FFFF, 8'h00);
    do_req(1'b0, 19'h00000, 8'h00);
    do_req(1'b0, 19'h2AAAA, 8'h00);
    do_req(1'b1, 19'h12345, 8'h3C);
    do_req(1'b0, 19'h12345, 8'h00);
    do_req(1'b0, 19'h00001, 8'h00);
    for (int i = 0; i < 8; i++) begin
      do_req(1'b1, 19'(i * 19'h0F0F1), 8'(i * 37 + 1));
      do_req(1'b0, 19'(i * 19'h0F0F1), 8'h00);
    end
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R3 all reads returned", expq.size(), 0);
    check(mem_cs_n && !mem_dq_oe, "R2 idle at end", {mem_cs_n, mem_dq_oe}, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule